// File: doc/BRIEF.md
# Multi-thread gate control list sequencer

This block drives the egress gates of a time-aware switch. One shared table holds gate control entries. Each entry gives a hold duration, a set of target ports, an override enable and a mask of traffic classes whose gates are closed. Up to eight execution threads each own a contiguous slice of that table. A thread walks its slice in a loop: it holds each entry for that entry's duration, then moves to the next entry, and after the last entry of the slice it returns to the first.

Threads are armed by a start command. A thread becomes active once the time-of-day input reaches a common operational base time plus that thread's own entry offset. One thread-count parameter limits which threads may run. The `tick_i` strobe marks each elapsed duration unit of 200 ns. `tod_i` carries the time of day in the same units. Configuration is written through three write ports: table entries, per-thread setup, and schedule parameters. These writes are accepted only while the engine is halted.

The output is one closed-gate mask per port. When no active thread claims a port, or the engine is halted, every gate on that port is open.

Top module: `gcl_sequencer`

## Requirements
- R1: After reset, every bit of `gate_closed_o` is 0, `stopped_o`=1, `started_o`=0, `thr_live_o`=0 and `cfg_err_o`=0. Thread offsets reset to 1, and all other configuration resets to 0.
- R2: Thread k becomes live at the first clock edge at which all of the following hold: the engine is running, `tod_i` >= base + offset[k], and k <= the active-thread-top value. A thread numbered above that top value never becomes live.
- R3: A thread that becomes live loads its start address. It holds each entry for exactly that entry's duration in `tick_i` pulses. It then advances by one index, and after holding the entry at its end index it returns to its start address.
- R4: For port p, bits [p*8 +: 8] of `gate_closed_o` equal the closed mask of a live thread's current entry when that entry has its override enable set to 1 and bit p of its port mask set. In every other case those bits are 0, and a 1 bit means that class's gate is closed.
- R5: When two live threads both claim the same port, the thread with the lower number sets that port's gates.
- R6: While a thread is not live, it closes no gates. While `stopped_o`=1, all of `gate_closed_o` is 0.
- R7: A `stop_i` pulse halts the engine at the next edge and clears every live thread. When `start_i` and `stop_i` are high in the same cycle, stop wins. A new start always begins each thread again at its start address.
- R8: A table, thread or parameter write made while the engine is running is discarded and sets `cfg_err_o`. An accepted start command clears `cfg_err_o`.
- R9: A table write whose duration is 0 or at least 2^19 is discarded and sets `cfg_err_o`. A thread write whose offset is 0 is discarded and sets `cfg_err_o`.
- R10: `stopped_o` is 1 exactly while the engine is halted. `started_o` is 1 while at least one thread is live. A live thread stays live until a stop command.
- R11: In the cycle in which a thread becomes live, a coincident `tick_i` is not counted, so the first entry is held for its full duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_i | input | TOD_W | Time of day in duration units |
| tick_i | input | 1 | One-cycle pulse per elapsed duration unit |
| start_i | input | 1 | Start command |
| stop_i | input | 1 | Stop command |
| tbl_we_i | input | 1 | Table entry write |
| tbl_addr_i | input | AW | Table entry index |
| tbl_dur_i | input | 20 | Entry duration in units |
| tbl_ports_i | input | 4 | Entry target port mask |
| tbl_ovr_i | input | 1 | Entry override enable |
| tbl_closed_i | input | 8 | Entry closed-class mask |
| thr_we_i | input | 1 | Thread setup write |
| thr_sel_i | input | TW | Thread number |
| thr_start_i | input | AW | Thread start address |
| thr_end_i | input | AW | Thread end index |
| thr_off_i | input | TOD_W | Thread entry offset |
| par_we_i | input | 1 | Schedule parameter write |
| par_base_i | input | TOD_W | Operational base time |
| par_top_i | input | TW | Highest active thread number |
| gate_closed_o | output | 32 | Closed-class mask per port |
| thr_live_o | output | N_THREADS | Live flag per thread |
| started_o | output | 1 | At least one thread live |
| stopped_o | output | 1 | Engine halted |
| cfg_err_o | output | 1 | Rejected configuration write |

## Verification
Two pairs of events can fall into the same cycle.

The first pair is thread activation and a duration tick. The bench raises `tick_i` in the very cycle in which `tod_i` reaches base plus offset. It then checks that the first entry still lasts its full two ticks before the next entry shows up.

The second pair is the start and stop commands, which the bench drives together. It then expects the engine to stay halted with every gate open.

A third case is a write made while the engine is running. The bench judges it at the ports: after a restart, the gates still show the entry that was written earlier.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
    localparam int GCL_PORTS     = 4;
    localparam int GCL_TCS       = 8;
    localparam int GCL_DUR_W     = 20;
    localparam int GCL_DUR_LIMIT = 1 << 19;

    typedef logic [GCL_DUR_W-1:0] gcl_dur_t;

    typedef struct packed {
        logic [GCL_PORTS-1:0] ports;
        logic                 ovr;
        logic [GCL_TCS-1:0]   closed;
    } gcl_gate_t;

    typedef enum logic {SEQ_HALT = 1'b0, SEQ_RUN = 1'b1} seq_state_t;

    function automatic logic gcl_dur_ok(gcl_dur_t d);
        return (d != '0) && (d < gcl_dur_t'(GCL_DUR_LIMIT));
    endfunction
endpackage

// File: rtl/gcl_cfg_store.sv
module gcl_cfg_store
    import gcl_pkg::*;
#(
    parameter int N_THREADS = 8,
    parameter int TBL_DEPTH = 16,
    parameter int TOD_W     = 32,
    parameter int AW        = $clog2(TBL_DEPTH),
    parameter int TW        = $clog2(N_THREADS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             running_i,
    input  logic             clr_err_i,
    input  logic             tbl_we_i,
    input  logic [AW-1:0]    tbl_addr_i,
    input  gcl_dur_t         tbl_dur_i,
    input  gcl_gate_t        tbl_gate_i,
    input  logic             thr_we_i,
    input  logic [TW-1:0]    thr_sel_i,
    input  logic [AW-1:0]    thr_start_i,
    input  logic [AW-1:0]    thr_end_i,
    input  logic [TOD_W-1:0] thr_off_i,
    input  logic             par_we_i,
    input  logic [TOD_W-1:0] par_base_i,
    input  logic [TW-1:0]    par_top_i,
    output gcl_dur_t         dur_o   [TBL_DEPTH],
    output gcl_gate_t        gate_o  [TBL_DEPTH],
    output logic [AW-1:0]    start_o [N_THREADS],
    output logic [AW-1:0]    end_o   [N_THREADS],
    output logic [TOD_W-1:0] off_o   [N_THREADS],
    output logic [TOD_W-1:0] base_o,
    output logic [TW-1:0]    top_o,
    output logic             err_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_DEPTH; i++) begin
                dur_o[i]  <= '0;
                gate_o[i] <= '0;
            end
            for (int k = 0; k < N_THREADS; k++) begin
                start_o[k] <= '0;
                end_o[k]   <= '0;
                off_o[k]   <= TOD_W'(1);
            end
            base_o <= '0;
            top_o  <= '0;
            err_o  <= 1'b0;
        end else begin
            if (clr_err_i) err_o <= 1'b0;
            if (tbl_we_i) begin
                if (running_i || !gcl_dur_ok(tbl_dur_i)) begin
                    err_o <= 1'b1;
                end else begin
                    dur_o[tbl_addr_i]  <= tbl_dur_i;
                    gate_o[tbl_addr_i] <= tbl_gate_i;
                end
            end
            if (thr_we_i) begin
                if (running_i || thr_off_i == '0) begin
                    err_o <= 1'b1;
                end else begin
                    start_o[thr_sel_i] <= thr_start_i;
                    end_o[thr_sel_i]   <= thr_end_i;
                    off_o[thr_sel_i]   <= thr_off_i;
                end
            end
            if (par_we_i) begin
                if (running_i) begin
                    err_o <= 1'b1;
                end else begin
                    base_o <= par_base_i;
                    top_o  <= par_top_i;
                end
            end
        end
    end

    // R8: a write during run is flagged
    p_write_while_running_r8: assert property (@(posedge clk) disable iff (rst)
        (running_i && (tbl_we_i || thr_we_i || par_we_i)) |=> err_o);

    // R9: an illegal duration is flagged
    p_bad_duration_r9: assert property (@(posedge clk) disable iff (rst)
        (tbl_we_i && !gcl_dur_ok(tbl_dur_i)) |=> err_o);
endmodule

// File: rtl/gcl_thread.sv
module gcl_thread
    import gcl_pkg::*;
#(
    parameter int TBL_DEPTH = 16,
    parameter int AW        = $clog2(TBL_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          arm_i,
    input  logic          tick_i,
    input  logic [AW-1:0] start_i,
    input  logic [AW-1:0] end_i,
    input  gcl_dur_t      dur_i [TBL_DEPTH],
    output logic          live_o,
    output logic [AW-1:0] idx_o
);
    gcl_dur_t      rem_q;
    logic [AW-1:0] nxt_idx;

    assign nxt_idx = (idx_o >= end_i) ? start_i : idx_o + AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_o <= 1'b0;
            idx_o  <= '0;
            rem_q  <= '0;
        end else if (!run_i) begin
            live_o <= 1'b0;
        end else if (!live_o) begin
            if (arm_i) begin
                live_o <= 1'b1;
                idx_o  <= start_i;
                rem_q  <= dur_i[start_i];
            end
        end else if (tick_i) begin
            if (rem_q <= gcl_dur_t'(1)) begin
                idx_o <= nxt_idx;
                rem_q <= dur_i[nxt_idx];
            end else begin
                rem_q <= rem_q - gcl_dur_t'(1);
            end
        end
    end

    // R3: a live thread stays inside its slice
    p_slice_bounds_r3: assert property (@(posedge clk) disable iff (rst)
        (live_o && start_i <= end_i) |-> (idx_o >= start_i && idx_o <= end_i));

    // R2: activation only follows a met start condition
    p_arm_before_live_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(live_o) |-> $past(arm_i));
endmodule

// File: rtl/gcl_gate_merge.sv
module gcl_gate_merge
    import gcl_pkg::*;
#(
    parameter int N_THREADS = 8,
    parameter int TBL_DEPTH = 16,
    parameter int AW        = $clog2(TBL_DEPTH)
) (
    input  logic                         live_i [N_THREADS],
    input  logic [AW-1:0]                idx_i  [N_THREADS],
    input  gcl_gate_t                    gate_i [TBL_DEPTH],
    output logic [GCL_PORTS*GCL_TCS-1:0] closed_o
);
    always_comb begin
        gcl_gate_t e;
        closed_o = '0;
        for (int p = 0; p < GCL_PORTS; p++) begin
            // walk downward so the lowest-numbered claimant is applied last
            for (int k = N_THREADS - 1; k >= 0; k--) begin
                e = gate_i[idx_i[k]];
                if (live_i[k] && e.ovr && e.ports[p]) begin
                    closed_o[p*GCL_TCS +: GCL_TCS] = e.closed;
                end
            end
        end
    end
endmodule

// File: rtl/gcl_sequencer.sv
module gcl_sequencer
    import gcl_pkg::*;
#(
    parameter int N_THREADS = 8,
    parameter int TBL_DEPTH = 16,
    parameter int TOD_W     = 32,
    parameter int AW        = $clog2(TBL_DEPTH),
    parameter int TW        = $clog2(N_THREADS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [TOD_W-1:0]             tod_i,
    input  logic                         tick_i,
    input  logic                         start_i,
    input  logic                         stop_i,
    input  logic                         tbl_we_i,
    input  logic [AW-1:0]                tbl_addr_i,
    input  logic [GCL_DUR_W-1:0]         tbl_dur_i,
    input  logic [GCL_PORTS-1:0]         tbl_ports_i,
    input  logic                         tbl_ovr_i,
    input  logic [GCL_TCS-1:0]           tbl_closed_i,
    input  logic                         thr_we_i,
    input  logic [TW-1:0]                thr_sel_i,
    input  logic [AW-1:0]                thr_start_i,
    input  logic [AW-1:0]                thr_end_i,
    input  logic [TOD_W-1:0]             thr_off_i,
    input  logic                         par_we_i,
    input  logic [TOD_W-1:0]             par_base_i,
    input  logic [TW-1:0]                par_top_i,
    output logic [GCL_PORTS*GCL_TCS-1:0] gate_closed_o,
    output logic [N_THREADS-1:0]         thr_live_o,
    output logic                         started_o,
    output logic                         stopped_o,
    output logic                         cfg_err_o
);
    seq_state_t state_q, state_d;
    logic       start_ok;

    assign start_ok = start_i && !stop_i && (state_q == SEQ_HALT);

    always_comb begin
        state_d = state_q;
        if (stop_i)       state_d = SEQ_HALT;
        else if (start_i) state_d = SEQ_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_HALT;
        else     state_q <= state_d;
    end

    gcl_dur_t         dur_tbl  [TBL_DEPTH];
    gcl_gate_t        gate_tbl [TBL_DEPTH];
    logic [AW-1:0]    thr_start [N_THREADS];
    logic [AW-1:0]    thr_end   [N_THREADS];
    logic [TOD_W-1:0] thr_off   [N_THREADS];
    logic [TOD_W-1:0] base_q;
    logic [TW-1:0]    top_q;
    gcl_gate_t        wr_gate;

    assign wr_gate = '{ports: tbl_ports_i, ovr: tbl_ovr_i, closed: tbl_closed_i};

    gcl_cfg_store #(.N_THREADS(N_THREADS), .TBL_DEPTH(TBL_DEPTH), .TOD_W(TOD_W),
                    .AW(AW), .TW(TW)) u_store (
        .clk(clk), .rst(rst),
        .running_i(state_q == SEQ_RUN), .clr_err_i(start_ok),
        .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_dur_i(tbl_dur_i),
        .tbl_gate_i(wr_gate),
        .thr_we_i(thr_we_i), .thr_sel_i(thr_sel_i), .thr_start_i(thr_start_i),
        .thr_end_i(thr_end_i), .thr_off_i(thr_off_i),
        .par_we_i(par_we_i), .par_base_i(par_base_i), .par_top_i(par_top_i),
        .dur_o(dur_tbl), .gate_o(gate_tbl), .start_o(thr_start), .end_o(thr_end),
        .off_o(thr_off), .base_o(base_q), .top_o(top_q), .err_o(cfg_err_o)
    );

    logic          live_arr [N_THREADS];
    logic [AW-1:0] idx_arr  [N_THREADS];

    for (genvar k = 0; k < N_THREADS; k++) begin : g_thr
        logic arm;
        assign arm = (TW'(k) <= top_q) &&
                     ({1'b0, tod_i} >= ({1'b0, base_q} + {1'b0, thr_off[k]}));

        gcl_thread #(.TBL_DEPTH(TBL_DEPTH), .AW(AW)) u_thr (
            .clk(clk), .rst(rst), .run_i(state_d == SEQ_RUN), .arm_i(arm),
            .tick_i(tick_i), .start_i(thr_start[k]), .end_i(thr_end[k]),
            .dur_i(dur_tbl), .live_o(live_arr[k]), .idx_o(idx_arr[k])
        );
        assign thr_live_o[k] = live_arr[k];

        // R10: a live thread persists until stopped
        p_live_sticky_r10: assert property (@(posedge clk) disable iff (rst)
            (thr_live_o[k] && !stop_i) |=> thr_live_o[k]);

        // R2: threads above the top value stay idle
        p_above_top_idle_r2: assert property (@(posedge clk) disable iff (rst)
            thr_live_o[k] |-> (TW'(k) <= top_q));
    end

    gcl_gate_merge #(.N_THREADS(N_THREADS), .TBL_DEPTH(TBL_DEPTH), .AW(AW)) u_merge (
        .live_i(live_arr), .idx_i(idx_arr), .gate_i(gate_tbl), .closed_o(gate_closed_o)
    );

    assign started_o = |thr_live_o;
    assign stopped_o = (state_q == SEQ_HALT);

    // R6: halted engine leaves every gate open
    p_open_when_halted_r6: assert property (@(posedge clk) disable iff (rst)
        stopped_o |-> (gate_closed_o == '0));

    // R7: stop takes effect at the next edge, whatever start does
    p_stop_wins_r7: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (stopped_o && !started_o));

    // R10: liveness implies running
    p_active_needs_run_r10: assert property (@(posedge clk) disable iff (rst)
        started_o |-> !stopped_o);
endmodule

// File: tb/gcl_sequencer_tb.sv
module gcl_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] tod_i;
    logic        tick_i, start_i, stop_i;
    logic        tbl_we_i;
    logic [3:0]  tbl_addr_i;
    logic [19:0] tbl_dur_i;
    logic [3:0]  tbl_ports_i;
    logic        tbl_ovr_i;
    logic [7:0]  tbl_closed_i;
    logic        thr_we_i;
    logic [2:0]  thr_sel_i;
    logic [3:0]  thr_start_i, thr_end_i;
    logic [31:0] thr_off_i;
    logic        par_we_i;
    logic [31:0] par_base_i;
    logic [2:0]  par_top_i;
    logic [31:0] gate_closed_o;
    logic [7:0]  thr_live_o;
    logic        started_o, stopped_o, cfg_err_o;

    int unsigned vectors = 0;
    int unsigned fails   = 0;
    int unsigned cycles  = 0;
    bit          done    = 1'b0;

    always #5 clk = ~clk;

    gcl_sequencer dut_i (
        .clk(clk), .rst(rst), .tod_i(tod_i), .tick_i(tick_i),
        .start_i(start_i), .stop_i(stop_i),
        .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_dur_i(tbl_dur_i),
        .tbl_ports_i(tbl_ports_i), .tbl_ovr_i(tbl_ovr_i), .tbl_closed_i(tbl_closed_i),
        .thr_we_i(thr_we_i), .thr_sel_i(thr_sel_i), .thr_start_i(thr_start_i),
        .thr_end_i(thr_end_i), .thr_off_i(thr_off_i),
        .par_we_i(par_we_i), .par_base_i(par_base_i), .par_top_i(par_top_i),
        .gate_closed_o(gate_closed_o), .thr_live_o(thr_live_o),
        .started_o(started_o), .stopped_o(stopped_o), .cfg_err_o(cfg_err_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic logic [7:0] pg(int p);
        return gate_closed_o[p*8 +: 8];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tbl_wr(int a, int d, int ports, bit ovr, int closed);
        tbl_addr_i = 4'(a); tbl_dur_i = 20'(d); tbl_ports_i = 4'(ports);
        tbl_ovr_i = ovr; tbl_closed_i = 8'(closed); tbl_we_i = 1'b1;
        cyc(); tbl_we_i = 1'b0;
    endtask

    task automatic thr_wr(int k, int s, int e, int off);
        thr_sel_i = 3'(k); thr_start_i = 4'(s); thr_end_i = 4'(e);
        thr_off_i = off; thr_we_i = 1'b1;
        cyc(); thr_we_i = 1'b0;
    endtask

    task automatic par_wr(int base, int top);
        par_base_i = base; par_top_i = 3'(top); par_we_i = 1'b1;
        cyc(); par_we_i = 1'b0;
    endtask

    task automatic do_start();
        start_i = 1'b1; cyc(); start_i = 1'b0;
    endtask

    task automatic do_stop();
        stop_i = 1'b1; cyc(); stop_i = 1'b0;
    endtask

    task automatic do_tick();
        tick_i = 1'b1; cyc(); tick_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 gates", gate_closed_o, 0);
        chk("R1 stopped", 32'(stopped_o), 1);
        chk("R1 started", 32'(started_o), 0);
        chk("R1 live", 32'(thr_live_o), 0);
        chk("R1 err", 32'(cfg_err_o), 0);
    endtask

    task automatic t_walk();
        tbl_wr(0, 2, 4'b0001, 1'b1, 8'h0F);
        tbl_wr(1, 1, 4'b0001, 1'b1, 8'hF0);
        tbl_wr(2, 3, 4'b0011, 1'b0, 8'hFF);
        thr_wr(0, 0, 2, 1);
        par_wr(10, 0);
        chk("R9 clean before bad writes", 32'(cfg_err_o), 0);
        tbl_wr(0, 0, 4'b0001, 1'b1, 8'hAA);
        chk("R9 zero duration flagged", 32'(cfg_err_o), 1);
        tbl_wr(1, 1 << 19, 4'b0001, 1'b1, 8'hAA);
        thr_wr(0, 2, 2, 0);
        tod_i = 5;
        do_start();
        chk("R8 start clears err", 32'(cfg_err_o), 0);
        chk("R10 running", 32'(stopped_o), 0);
        chk("R6 not yet live", 32'(started_o), 0);
        chk("R6 gates open", gate_closed_o, 0);
        tod_i = 10; cyc();
        chk("R2 below base+offset", 32'(thr_live_o), 0);
        tod_i = 11; tick_i = 1'b1; cyc(); tick_i = 1'b0;
        chk("R2 live at base+offset", 32'(thr_live_o), 1);
        chk("R10 started", 32'(started_o), 1);
        chk("R9 entry0 kept", 32'(pg(0)), 8'h0F);
        do_tick();
        chk("R11 coincident tick not counted", 32'(pg(0)), 8'h0F);
        do_tick();
        chk("R3 advance to entry1", 32'(pg(0)), 8'hF0);
        chk("R4 port1 not targeted", 32'(pg(1)), 0);
        do_tick();
        chk("R4 override off port0", 32'(pg(0)), 0);
        chk("R4 override off port1", 32'(pg(1)), 0);
        do_tick(); do_tick();
        chk("R3 entry2 held 3 ticks", 32'(pg(0)), 0);
        do_tick();
        chk("R3 wrap to start", 32'(pg(0)), 8'h0F);
        do_stop();
        chk("R7 stopped", 32'(stopped_o), 1);
        chk("R7 no live thread", 32'(thr_live_o), 0);
        chk("R6 open after stop", gate_closed_o, 0);
    endtask

    task automatic t_run_write();
        do_start();
        chk("R7 restart live", 32'(thr_live_o), 1);
        tbl_wr(0, 2, 4'b0001, 1'b1, 8'h33);
        chk("R8 write while running flagged", 32'(cfg_err_o), 1);
        chk("R8 gates unchanged", 32'(pg(0)), 8'h0F);
        do_stop();
        do_start();
        chk("R8 entry0 still original", 32'(pg(0)), 8'h0F);
        chk("R8 err cleared by start", 32'(cfg_err_o), 0);
        do_stop();
    endtask

    task automatic t_priority();
        tbl_wr(4, 4, 4'b0001, 1'b1, 8'h0F);
        tbl_wr(5, 4, 4'b0011, 1'b1, 8'hF0);
        thr_wr(0, 4, 4, 1);
        thr_wr(1, 5, 5, 3);
        thr_wr(2, 5, 5, 1);
        par_wr(20, 1);
        tod_i = 0;
        do_start();
        chk("R2 not armed", 32'(thr_live_o), 0);
        tod_i = 21; cyc();
        chk("R2 thread0 only, thread2 above top", 32'(thr_live_o), 1);
        chk("R4 port1 open", 32'(pg(1)), 0);
        tod_i = 22; cyc();
        chk("R2 thread1 offset pending", 32'(thr_live_o), 1);
        tod_i = 23; cyc();
        chk("R2 thread1 live", 32'(thr_live_o), 3);
        chk("R5 lower thread wins port0", 32'(pg(0)), 8'h0F);
        chk("R5 port1 from thread1", 32'(pg(1)), 8'hF0);
        do_stop();
    endtask

    task automatic t_start_stop_same();
        start_i = 1'b1; stop_i = 1'b1; cyc(); start_i = 1'b0; stop_i = 1'b0;
        chk("R7 stop wins stopped", 32'(stopped_o), 1);
        chk("R7 stop wins no live", 32'(started_o), 0);
        chk("R6 gates open", gate_closed_o, 0);
    endtask

    initial begin
        rst = 1'b1; tod_i = 0; tick_i = 0; start_i = 0; stop_i = 0;
        tbl_we_i = 0; tbl_addr_i = 0; tbl_dur_i = 0; tbl_ports_i = 0;
        tbl_ovr_i = 0; tbl_closed_i = 0;
        thr_we_i = 0; thr_sel_i = 0; thr_start_i = 0; thr_end_i = 0; thr_off_i = 0;
        par_we_i = 0; par_base_i = 0; par_top_i = 0;
        cyc(); cyc(); cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_walk();
        t_run_write();
        t_priority();
        t_start_stop_same();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule